// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers event pulses from a set of DMA channel engines and turns them into one shared interrupt line. Each channel reports three kinds of events: transfer done, and two independent error classes. Every event pulse is held in a sticky per-channel, per-class flag. Software enables or blocks each flag through its own enable register. The interrupt line is raised while any enabled flag is set.

Software reaches the block over a simple 32-bit register port. A summary register ORs the three enabled-event views per channel, so a handler can scan it from bit 0 upward and service the lowest channel first. Flags are cleared by writing ones to the raw register of the matching class. Clearing one class never touches another class. A read-only register reports which channels are running a transfer. The channel count is a parameter, with a default of 16.

Top module: `dma_irq_hub`

## Requirements
- R1: After synchronous reset, all flags and enable masks are zero, `irq` is low and `bus_rdata` is zero.
- R2: A one-cycle pulse on bit i of `tc_evt`, `err1_evt` or `err2_evt` sets bit i of that class's raw register. The raw registers are at 0x600 (done), 0x608 (error 1) and 0x610 (error 2).
- R3: The enable masks are at 0x018 (done), 0x020 (error 1) and 0x024 (error 2). Each is read/write. Bit i set to 1 enables channel i. Only the low NUM_CH bits are stored, and the upper bits read as zero.
- R4: The status registers at 0x004 (done), 0x00C (error 1) and 0x010 (error 2) read as that class's raw value ANDed with its mask.
- R5: The summary register at 0x000 reads as the bitwise OR of the three status values, with bit i belonging to channel i.
- R6: `irq` is a register. It is high in the cycle after the summary value is nonzero, and low in the cycle after it becomes zero.
- R7: Writing to a raw register clears exactly the bits written as 1 in that class. Bits written as 0 are kept, and the other classes are left unchanged.
- R8: If an event pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R9: The busy register at 0x690 returns `ch_busy` as sampled in the read cycle.
- R10: Reads of any other offset, including unaligned ones, return zero. Writes to other offsets, and to the status, summary and busy registers, change no state.
- R11: A read is a cycle with `bus_req`=1 and `bus_wr`=0. Its data appears on `bus_rdata` after the next rising edge and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| tc_evt | input | NUM_CH | Transfer-done event pulses, one bit per channel |
| err1_evt | input | NUM_CH | Error class 1 event pulses |
| err2_evt | input | NUM_CH | Error class 2 event pulses |
| ch_busy | input | NUM_CH | Channel running levels |
| irq | output | 1 | Shared interrupt, registered |

## Verification
The assertions assume that the event inputs are known (never X) in every cycle after reset, and that the inputs hold defined values during reset. Under that assumption, a flag can fall only in the cycle after a clear write to that class. The bench keeps to these assumptions in three ways. It drives all inputs to zero from time zero. It changes inputs only on falling clock edges. It issues a single access per request cycle. The coincident event-and-clear case is produced on purpose, by raising an event bit and a clear write in the same cycle.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int NUM_CLASS = 3;

  typedef enum logic [1:0] {
    CLS_DONE = 2'd0,
    CLS_ERR1 = 2'd1,
    CLS_ERR2 = 2'd2
  } evt_class_e;

  localparam logic [11:0] OFF_SUMMARY = 12'h000;
  localparam logic [11:0] OFF_BUSY    = 12'h690;

  function automatic logic [11:0] stat_off(input int c);
    case (c)
      0:       return 12'h004;
      1:       return 12'h00C;
      default: return 12'h010;
    endcase
  endfunction

  function automatic logic [11:0] mask_off(input int c);
    case (c)
      0:       return 12'h018;
      1:       return 12'h020;
      default: return 12'h024;
    endcase
  endfunction

  function automatic logic [11:0] raw_off(input int c);
    case (c)
      0:       return 12'h600;
      1:       return 12'h608;
      default: return 12'h610;
    endcase
  endfunction
endpackage

// File: rtl/irq_evt_latch.sv
module irq_evt_latch #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] evt,
  input  logic [NUM_CH-1:0] clr,
  output logic [NUM_CH-1:0] raw
);
  // A new pulse takes priority over a clear of the same bit.
  always_ff @(posedge clk) begin
    if (rst) raw <= '0;
    else     raw <= (raw & ~clr) | evt;
  end
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int NUM_CH    = 16,
  parameter int NUM_CLASS = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_CLASS-1:0][NUM_CH-1:0] raw,
  input  logic [NUM_CLASS-1:0][NUM_CH-1:0] mask,
  output logic [NUM_CLASS-1:0][NUM_CH-1:0] stat,
  output logic [NUM_CH-1:0]                summary,
  output logic                             irq
);
  always_comb begin
    summary = '0;
    for (int c = 0; c < NUM_CLASS; c++) begin
      stat[c] = raw[c] & mask[c];
      summary = summary | stat[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |summary;
  end
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int NUM_CLASS = 3,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             bus_req,
  input  logic                             bus_wr,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic [DATA_W-1:0]                bus_wdata,
  output logic [DATA_W-1:0]                bus_rdata,
  input  logic [NUM_CLASS-1:0][NUM_CH-1:0] raw,
  input  logic [NUM_CLASS-1:0][NUM_CH-1:0] stat,
  input  logic [NUM_CH-1:0]                summary,
  input  logic [NUM_CH-1:0]                busy,
  output logic [NUM_CLASS-1:0][NUM_CH-1:0] mask,
  output logic [NUM_CLASS-1:0][NUM_CH-1:0] clr
);
  localparam int PAD = DATA_W - NUM_CH;

  logic              wr_cyc;
  logic              rd_cyc;
  logic [NUM_CH-1:0] wbits;
  logic [NUM_CH-1:0] rd_sel;
  logic              unused_wbits;

  assign wr_cyc       = bus_req & bus_wr;
  assign rd_cyc       = bus_req & ~bus_wr;
  assign wbits        = bus_wdata[NUM_CH-1:0];
  assign unused_wbits = ^bus_wdata[DATA_W-1:NUM_CH];

  // Write-one-to-clear strobes, one vector per class
  always_comb begin
    for (int c = 0; c < NUM_CLASS; c++) begin
      clr[c] = (wr_cyc && bus_addr == ADDR_W'(raw_off(c))) ? wbits : '0;
    end
  end

  // Enable masks
  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
    end else if (wr_cyc) begin
      for (int c = 0; c < NUM_CLASS; c++) begin
        if (bus_addr == ADDR_W'(mask_off(c))) mask[c] <= wbits;
      end
    end
  end

  // Read select; unmatched offsets fall through to zero
  always_comb begin
    rd_sel = '0;
    if (bus_addr == ADDR_W'(OFF_SUMMARY)) rd_sel = summary;
    if (bus_addr == ADDR_W'(OFF_BUSY))    rd_sel = busy;
    for (int c = 0; c < NUM_CLASS; c++) begin
      if (bus_addr == ADDR_W'(stat_off(c))) rd_sel = stat[c];
      if (bus_addr == ADDR_W'(mask_off(c))) rd_sel = mask[c];
      if (bus_addr == ADDR_W'(raw_off(c)))  rd_sel = raw[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_cyc) bus_rdata <= {{PAD{1'b0}}, rd_sel};
  end
endmodule

// File: rtl/dma_irq_hub.sv
module dma_irq_hub
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] tc_evt,
  input  logic [NUM_CH-1:0] err1_evt,
  input  logic [NUM_CH-1:0] err2_evt,
  input  logic [NUM_CH-1:0] ch_busy,
  output logic              irq
);
  logic [NUM_CLASS-1:0][NUM_CH-1:0] evt_v;
  logic [NUM_CLASS-1:0][NUM_CH-1:0] raw_v;
  logic [NUM_CLASS-1:0][NUM_CH-1:0] clr_v;
  logic [NUM_CLASS-1:0][NUM_CH-1:0] mask_v;
  logic [NUM_CLASS-1:0][NUM_CH-1:0] stat_v;
  logic [NUM_CH-1:0]                summary;

  assign evt_v[CLS_DONE] = tc_evt;
  assign evt_v[CLS_ERR1] = err1_evt;
  assign evt_v[CLS_ERR2] = err2_evt;

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
    irq_evt_latch #(.NUM_CH(NUM_CH)) u_latch (
      .clk (clk),
      .rst (rst),
      .evt (evt_v[c]),
      .clr (clr_v[c]),
      .raw (raw_v[c])
    );
  end

  irq_combine #(.NUM_CH(NUM_CH), .NUM_CLASS(NUM_CLASS)) u_combine (
    .clk     (clk),
    .rst     (rst),
    .raw     (raw_v),
    .mask    (mask_v),
    .stat    (stat_v),
    .summary (summary),
    .irq     (irq)
  );

  irq_reg_file #(
    .NUM_CH(NUM_CH), .NUM_CLASS(NUM_CLASS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .raw       (raw_v),
    .stat      (stat_v),
    .summary   (summary),
    .busy      (ch_busy),
    .mask      (mask_v),
    .clr       (clr_v)
  );
endmodule

// File: rtl/dma_irq_hub_chk.sv
module dma_irq_hub_chk
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input logic                             clk,
  input logic                             rst,
  input logic [NUM_CLASS-1:0][NUM_CH-1:0] evt,
  input logic [NUM_CLASS-1:0][NUM_CH-1:0] clr,
  input logic [NUM_CLASS-1:0][NUM_CH-1:0] raw,
  input logic [NUM_CH-1:0]                summary,
  input logic                             irq
);
  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
    // R2: every pulsed bit is held in its class flag on the next cycle
    a_r2_event_sets_raw: assert property (@(posedge clk) disable iff (rst)
      (evt[c] != '0) |=> ((raw[c] & $past(evt[c])) == $past(evt[c])));

    // R8: a pulse coinciding with a clear of the same bit leaves it set
    a_r8_event_over_clear: assert property (@(posedge clk) disable iff (rst)
      ((evt[c] & clr[c]) != '0) |=>
        ((raw[c] & $past(evt[c] & clr[c])) == $past(evt[c] & clr[c])));

    // R7: a flag can only fall where a clear strobe for its class was set
    a_r7_fall_needs_clear: assert property (@(posedge clk) disable iff (rst)
      (($past(raw[c]) & ~raw[c] & ~$past(clr[c])) == '0));
  end

  // R6: the interrupt tracks the summary one cycle later
  a_r6_irq_follows_summary: assert property (@(posedge clk) disable iff (rst)
    irq == ($past(summary) != '0));
endmodule

bind dma_irq_hub dma_irq_hub_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .evt     (evt_v),
  .clr     (clr_v),
  .raw     (raw_v),
  .summary (summary),
  .irq     (irq)
);

// File: tb/tb_dma_irq_hub.sv
`timescale 1ns/1ps
module tb_dma_irq_hub;
  localparam int NCH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] tc_evt = '0, err1_evt = '0, err2_evt = '0, ch_busy = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [NCH-1:0] raw_m  [3];
  logic [NCH-1:0] mask_m [3];
  logic [11:0] stat_o [3] = '{12'h004, 12'h00C, 12'h010};
  logic [11:0] mask_o [3] = '{12'h018, 12'h020, 12'h024};
  logic [11:0] raw_o  [3] = '{12'h600, 12'h608, 12'h610};

  always #2 clk = ~clk;

  dma_irq_hub #(.NUM_CH(NCH), .ADDR_W(12), .DATA_W(32)) dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tc_evt(tc_evt), .err1_evt(err1_evt), .err2_evt(err2_evt),
    .ch_busy(ch_busy), .irq(irq)
  );

  function automatic logic [NCH-1:0] exp_sum();
    logic [NCH-1:0] s = '0;
    for (int c = 0; c < 3; c++) s = s | (raw_m[c] & mask_m[c]);
    return s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_evt(input int c, input logic [NCH-1:0] v);
    case (c)
      0: tc_evt = v;
      1: err1_evt = v;
      default: err2_evt = v;
    endcase
  endtask

  task automatic pulse(input int c, input int ch);
    @(negedge clk);
    set_evt(c, NCH'(1) << ch);
    @(negedge clk);
    set_evt(c, '0);
    raw_m[c][ch] = 1'b1;
  endtask

  task automatic chk_irq(input string tag);
    @(negedge clk);
    chk(tag, {31'b0, irq}, {31'b0, exp_sum() != '0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    for (int c = 0; c < 3; c++) begin raw_m[c] = '0; mask_m[c] = '0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    for (int c = 0; c < 3; c++) begin
      bus_read(raw_o[c], rd);  chk("R1 raw", rd, 32'h0);
      bus_read(mask_o[c], rd); chk("R1 mask", rd, 32'h0);
      bus_read(stat_o[c], rd); chk("R1 stat", rd, 32'h0);
    end

    // R3: mask width and read-back
    bus_write(mask_o[0], 32'hFFFF_FFFF);
    bus_read(mask_o[0], rd); chk("R3 upper bits zero", rd, 32'h0000_FFFF);
    mask_m[0] = 16'hFFFF; mask_m[1] = 16'hA5A5; mask_m[2] = 16'h0F0F;
    for (int c = 1; c < 3; c++) bus_write(mask_o[c], {16'h0, mask_m[c]});
    for (int c = 0; c < 3; c++) begin
      bus_read(mask_o[c], rd); chk("R3 mask readback", rd, {16'h0, mask_m[c]});
    end

    // Sweep every class and channel: R2 R4 R5 R6 R7
    for (int c = 0; c < 3; c++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        pulse(c, ch);
        bus_read(raw_o[c], rd);    chk("R2 raw set", rd, {16'h0, raw_m[c]});
        bus_read(stat_o[c], rd);   chk("R4 status", rd, {16'h0, raw_m[c] & mask_m[c]});
        bus_read(12'h000, rd);     chk("R5 summary", rd, {16'h0, exp_sum()});
        chk_irq("R6 irq set");
        bus_write(raw_o[c], 32'h1 << ch);
        raw_m[c][ch] = 1'b0;
        bus_read(raw_o[c], rd);    chk("R7 cleared", rd, {16'h0, raw_m[c]});
        chk_irq("R6 irq clear");
      end
    end

    // R7: class independence on one channel, partial clear
    @(negedge clk);
    tc_evt = 16'h0008; err1_evt = 16'h0008; err2_evt = 16'h0108;
    @(negedge clk);
    tc_evt = '0; err1_evt = '0; err2_evt = '0;
    raw_m[0] = 16'h0008; raw_m[1] = 16'h0008; raw_m[2] = 16'h0108;
    bus_write(raw_o[1], 32'h0000_0008); raw_m[1] = '0;
    bus_read(raw_o[0], rd); chk("R7 done kept", rd, 32'h0008);
    bus_read(raw_o[1], rd); chk("R7 err1 cleared", rd, 32'h0);
    bus_read(raw_o[2], rd); chk("R7 err2 kept", rd, 32'h0108);
    bus_write(raw_o[2], 32'h0000_0100); raw_m[2] = 16'h0008;
    bus_read(raw_o[2], rd); chk("R7 zero bits kept", rd, 32'h0008);
    bus_write(raw_o[0], 32'h0008); raw_m[0] = '0;
    bus_read(raw_o[2], rd); chk("R7 err2 after done clear", rd, 32'h0008);
    bus_write(raw_o[2], 32'h0008); raw_m[2] = '0;
    chk_irq("R6 all clear");

    // R8: event and clear in the same cycle
    pulse(0, 6);
    @(negedge clk);
    tc_evt = 16'h0020;
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = raw_o[0]; bus_wdata = 32'h0060;
    @(negedge clk);
    tc_evt = '0; bus_req = 1'b0; bus_wr = 1'b0;
    raw_m[0] = 16'h0020;
    bus_read(raw_o[0], rd); chk("R8 event wins", rd, 32'h0020);

    // R9: busy levels
    ch_busy = 16'hC3A5;
    bus_read(12'h690, rd); chk("R9 busy", rd, 32'hC3A5);
    ch_busy = 16'h0001;
    bus_read(12'h690, rd); chk("R9 busy change", rd, 32'h0001);
    ch_busy = '0;

    // R10: undefined offsets and read-only registers
    bus_write(12'h004, 32'hFFFF);
    bus_write(12'h000, 32'hFFFF);
    bus_write(12'h690, 32'hFFFF);
    bus_write(12'h100, 32'hFFFF);
    bus_write(12'h014, 32'hFFFF);
    bus_read(12'h100, rd); chk("R10 undefined read", rd, 32'h0);
    bus_read(12'h014, rd); chk("R10 gap read", rd, 32'h0);
    bus_read(12'h602, rd); chk("R10 unaligned read", rd, 32'h0);
    bus_read(raw_o[0], rd); chk("R10 raw unchanged", rd, 32'h0020);
    bus_read(stat_o[0], rd); chk("R10 status unchanged", rd, 32'h0020);
    for (int c = 0; c < 3; c++) begin
      bus_read(mask_o[c], rd); chk("R10 mask unchanged", rd, {16'h0, mask_m[c]});
    end
    bus_write(raw_o[0], 32'h0020); raw_m[0] = '0;
    chk_irq("R6 low at end");

    // R11: read data holds across idle cycles and writes
    bus_read(mask_o[1], rd); chk("R11 read", rd, 32'hA5A5);
    repeat (3) @(negedge clk);
    chk("R11 hold idle", bus_rdata, 32'hA5A5);
    bus_write(mask_o[2], 32'h1234); mask_m[2] = 16'h1234;
    chk("R11 hold write", bus_rdata, 32'hA5A5);
    bus_read(mask_o[2], rd); chk("R11 new read", rd, 32'h1234);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule